// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-programmed master for the two-wire PHY management bus. It covers both the 5-bit-register frame format (Clause 22) and the extended-address format (Clause 45). Software fills an address word and a write-data word. It then writes a command word with its start bit set. The block generates the management clock from the system clock and shifts out a single 64-bit frame. On a write it drives the data pin for the whole frame. On a read it releases the pin at the turnaround and samples the 16 data bits the PHY returns.

When the frame finishes, the start bit drops back to 0. A read also records whether the PHY answered, in a sticky failure bit that software checks once the start bit has cleared. Multi-step Clause 45 accesses (an address frame followed by a data or read frame) are issued by software as separate commands, one per frame.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads 0, MDC is low and the data pin is released (output enable 0).
- R2: Register byte offsets are command 0x00, address 0x04, write data 0x08, read data 0x0C and status 0x10. Command bits are: register/device number [4:0], port address [9:5], opcode [11:10], frame type [13:12] and start [14]. Frame type 0 selects Clause 45 and 1 selects Clause 22.
- R3: Every frame is 64 bits sent MSB first: 32 ones, the two frame-type bits, the two opcode bits, the 5-bit port, the 5-bit register/device number, the turnaround and 16 data bits. A non-read frame sends turnaround 1 then 0.
- R4: A Clause 45 frame with opcode 0 carries address[15:0] in its data field. Every other non-read frame carries write-data[15:0].
- R5: Read frames are Clause 22 opcode 2 and Clause 45 opcodes 2 and 3. For these the master drives bits 0..45 and releases the pin from bit 46 to the end of the frame. The 16 bits sampled in bits 48..63 land MSB first in read-data[15:0], with the upper half 0.
- R6: The start bit reads 1 while a frame runs and returns to 0 when it completes. Between frames MDC stays low and the pin stays released.
- R7: A command-register write while the start bit reads 1 is ignored. This holds even in the final cycle of a frame: the fields and the frame on the wire do not change, and no new frame starts.
- R8: Status bit 0 is set when the second turnaround bit (bit 47) of a read is sampled as 1. It is cleared when the next command is accepted, and a read that does get an answer leaves it at 0.
- R9: One MDC period lasts 2*MDC_HALF system clocks. The master changes the pin one clock after an MDC rising edge and samples read data on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe | output | 1 | Data pin output enable (1 = master drives) |
| mdio_i | input | 1 | Data pin input value (pulled high when nobody drives) |

## Verification
The risky coincidence is a command write that lands in the same cycle in which the running frame completes and the start bit is about to clear. The bench counts MDC falling edges on the wire. On the falling edge that ends the frame, it issues a command write in the very next clock cycle. That write must be dropped: the command fields must read back unchanged, and no further MDC edge may appear. A second coincidence also gets a check: accepting a new command must clear a failure flag that an earlier unanswered read had left set.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_LEN = 64;
    localparam int PRE_LEN   = 32;
    localparam int DATA_W    = 16;
    localparam int TA_IDX    = 46;
    localparam int TA2_IDX   = 47;
    localparam int LAST_IDX  = FRAME_LEN - 1;
    localparam int START_BIT = 14;

    localparam logic [4:0] OFF_CMD  = 5'h00;
    localparam logic [4:0] OFF_ADDR = 5'h04;
    localparam logic [4:0] OFF_WDAT = 5'h08;
    localparam logic [4:0] OFF_RDAT = 5'h0C;
    localparam logic [4:0] OFF_STAT = 5'h10;

    localparam logic [1:0] ST_C45 = 2'b00;
    localparam logic [1:0] ST_C22 = 2'b01;

    // Field order mirrors command bits 13:0
    typedef struct packed {
        logic [1:0] st;
        logic [1:0] op;
        logic [4:0] pa;
        logic [4:0] ra;
    } mdio_cmd_t;

    function automatic logic op_is_read(mdio_cmd_t c);
        return (c.st == ST_C22) ? (c.op == 2'b10) : c.op[1];
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(mdio_cmd_t c,
                                                         logic [DATA_W-1:0] addr_v,
                                                         logic [DATA_W-1:0] wr_v);
        logic [DATA_W-1:0] d;
        d = (c.st == ST_C45 && c.op == 2'b00) ? addr_v : wr_v;
        return {{PRE_LEN{1'b1}}, c.st, c.op, c.pa, c.ra, 2'b10, d};
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int HALF = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_p,
    output logic fall_p
);
    localparam int CNT_W = (HALF < 2) ? 1 : $clog2(HALF);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            mdc    <= 1'b0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (cnt == CNT_TOP) begin
                cnt    <= '0;
                mdc    <= ~mdc;
                rise_p <= ~mdc;
                fall_p <= mdc;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] addr_v,
    input  logic [DATA_W-1:0] wr_v,
    input  logic              rise_p,
    input  logic              fall_p,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              rd_kind,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fail
);
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] IDX_REL  = IDX_W'(TA_IDX - 1);
    localparam logic [IDX_W-1:0] IDX_TA2  = IDX_W'(TA2_IDX);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LAST_IDX);

    logic [FRAME_LEN-1:0] shreg;
    logic [FRAME_LEN-1:0] frame_w;
    logic [IDX_W-1:0]     idx;
    logic                 last;

    assign frame_w = build_frame(cmd, addr_v, wr_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            shreg   <= '0;
            idx     <= '0;
            last    <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rd_kind <= 1'b0;
            rd_data <= '0;
            rd_fail <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                busy    <= 1'b1;
                shreg   <= frame_w;
                mdio_o  <= frame_w[FRAME_LEN-1];
                mdio_oe <= 1'b1;
                idx     <= '0;
                last    <= 1'b0;
                rd_kind <= op_is_read(cmd);
                rd_data <= '0;
                rd_fail <= 1'b0;
            end else if (busy) begin
                if (rise_p) begin
                    if (rd_kind && idx == IDX_TA2)
                        rd_fail <= mdio_i;
                    if (rd_kind && idx > IDX_TA2)
                        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
                    if (idx == IDX_LAST) begin
                        last <= 1'b1;
                    end else begin
                        idx    <= idx + 1'b1;
                        shreg  <= shreg << 1;
                        mdio_o <= shreg[FRAME_LEN-2];
                        if (rd_kind && idx >= IDX_REL)
                            mdio_oe <= 1'b0;
                    end
                end
                if (fall_p && last) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    // R9
    mdio_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o)))
        |-> $past(rise_p));

    // R5
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_kind && idx > IDX_W'(TA_IDX)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [4:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t         cmd_q;
    logic [31:0]       addr_q;
    logic [31:0]       wdat_q;
    logic [DATA_W-1:0] rdat_q;
    logic              fail_q;

    logic              busy, done, rd_kind, rd_fail, rise_p, fall_p, go;
    logic [DATA_W-1:0] rd_data;
    logic              cmd_wr;

    assign cmd_wr = reg_wr && (reg_addr == OFF_CMD);
    assign go     = cmd_wr && reg_wdata[START_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            fail_q <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    OFF_CMD:  if (!busy) cmd_q <= mdio_cmd_t'(reg_wdata[13:0]);
                    OFF_ADDR: addr_q <= reg_wdata;
                    OFF_WDAT: wdat_q <= reg_wdata;
                    default:  ;
                endcase
            end
            if (go) begin
                fail_q <= 1'b0;
            end else if (done && rd_kind) begin
                rdat_q <= rd_data;
                fail_q <= rd_fail;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFF_CMD:  reg_rdata = {17'd0, busy, cmd_q};
            OFF_ADDR: reg_rdata = addr_q;
            OFF_WDAT: reg_rdata = wdat_q;
            OFF_RDAT: reg_rdata = {16'd0, rdat_q};
            OFF_STAT: reg_rdata = {31'd0, fail_q};
            default:  reg_rdata = '0;
        endcase
    end

    mdio_clk_div #(.HALF(MDC_HALF)) clk_div_i (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame_eng eng_i (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .cmd     (mdio_cmd_t'(reg_wdata[13:0])),
        .addr_v  (addr_q[DATA_W-1:0]),
        .wr_v    (wdat_q[DATA_W-1:0]),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rd_kind (rd_kind),
        .rd_data (rd_data),
        .rd_fail (rd_fail)
    );

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> $stable(cmd_q));

    // R8
    fail_clear_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> !fail_q);

    // R6
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdio_oe && !mdc));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !fail_q && cmd_q == '0));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = 5'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.MDC_HALF(HALF)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // wire observer and PHY model
    logic cap_bits [0:63];
    logic cap_oe   [0:63];
    int   rcnt = 0;
    int   fcnt = 0;
    bit   phy_resp = 0;
    logic [15:0] phy_data = 16'h0;
    time  t_r0 = 0, t_r1 = 0;

    always @(posedge mdc) begin
        if (rcnt == 0) t_r0 = $time;
        if (rcnt == 1) t_r1 = $time;
        if (rcnt < 64) begin
            cap_bits[rcnt] = mdio_o;
            cap_oe[rcnt]   = mdio_oe;
        end
        rcnt++;
    end

    always @(negedge mdc) begin
        if (phy_resp) begin
            if (fcnt == 46) mdio_i = 1'b0;
            else if (fcnt >= 47 && fcnt <= 62) mdio_i = phy_data[62 - fcnt];
            else if (fcnt == 63) mdio_i = 1'b1;
        end
        fcnt++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input logic [1:0] st, input logic [1:0] op,
                                             input logic [4:0] pa, input logic [4:0] ra);
        return {17'd0, 1'b1, st, op, pa, ra};
    endfunction

    function automatic bit is_rd(input logic [1:0] st, input logic [1:0] op);
        if (st == 2'b01) return op == 2'b10;
        return op == 2'b10 || op == 2'b11;
    endfunction

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd_reg(5'h00, v);
            if (!v[14]) return;
        end
    endtask

    task automatic check_wire(input logic [1:0] st, input logic [1:0] op, input logic [4:0] pa,
                              input logic [4:0] ra, input logic [15:0] av, input logic [15:0] wv,
                              input string req);
        logic [63:0] exp, act, oexp, oact;
        logic [15:0] d;
        bit rd;
        rd = is_rd(st, op);
        d = (st == 2'b00 && op == 2'b00) ? av : wv;
        exp = {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
        for (int k = 0; k < 64; k++) begin
            act[63-k]  = cap_bits[k];
            oact[63-k] = cap_oe[k];
            oexp[63-k] = rd ? (k < 46) : 1'b1;
        end
        if (rd) begin
            act[17:0] = 18'd0;
            exp[17:0] = 18'd0;
        end
        chk(rcnt == 64 && act == exp, req, act, exp);
        chk(oact == oexp, rd ? "R5 oe" : "R3 oe", oact, oexp);
    endtask

    task automatic run_frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] pa,
                             input logic [4:0] ra, input logic [15:0] av, input logic [15:0] wv,
                             input bit resp, input logic [15:0] pd, input string req);
        logic [31:0] v;
        wr_reg(5'h04, {16'hA5A5, av});
        wr_reg(5'h08, {16'h5A5A, wv});
        phy_resp = resp; phy_data = pd; rcnt = 0; fcnt = 0; mdio_i = 1'b1;
        wr_reg(5'h00, cmd_word(st, op, pa, ra));
        rd_reg(5'h00, v);
        chk(v[14] == 1'b1, "R6 start busy", {32'd0, v}, 64'h4000);
        wait_idle();
        rd_reg(5'h00, v);
        chk(v == {18'd0, st, op, pa, ra}, "R6 start cleared", {32'd0, v}, {50'd0, st, op, pa, ra});
        chk(!mdc && !mdio_oe, "R6 idle bus", {62'd0, mdc, mdio_oe}, 64'd0);
        check_wire(st, op, pa, ra, av, wv, req);
        if (is_rd(st, op)) begin
            rd_reg(5'h0C, v);
            chk(v == (resp ? {16'd0, pd} : 32'h0000_FFFF), "R5 read data", {32'd0, v},
                resp ? {48'd0, pd} : 64'hFFFF);
            rd_reg(5'h10, v);
            chk(v == (resp ? 32'd0 : 32'd1), "R8 status", {32'd0, v}, resp ? 64'd0 : 64'd1);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (400000 / 2) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int a = 0; a <= 16; a += 4) begin
            rd_reg(5'(a), v);
            chk(v == 32'd0, "R1 reg reset", {32'd0, v}, 64'd0);
        end
        chk(!mdc && !mdio_oe, "R1 pins", {62'd0, mdc, mdio_oe}, 64'd0);

        // R2 R3 R4: Clause 22 write sweep
        for (int i = 0; i < 8; i++)
            run_frame(2'b01, 2'b01, 5'(i*4+1), 5'(31-i*3), 16'h0F0F, 16'h1234 ^ 16'(i*16'h1111),
                      0, 16'h0, "R3 c22 write frame");

        // R4: Clause 45 address and data writes
        for (int i = 0; i < 3; i++) begin
            run_frame(2'b00, 2'b00, 5'(i*9+2), 5'(i+1), 16'hBEE0 + 16'(i), 16'h7777, 0, 16'h0, "R4 c45 addr frame");
            run_frame(2'b00, 2'b01, 5'(i*9+2), 5'(i+1), 16'h3C3C, 16'hC001 + 16'(i), 0, 16'h0, "R4 c45 data frame");
        end

        // R5: reads in all three read opcodes
        for (int i = 0; i < 4; i++) begin
            run_frame(2'b01, 2'b10, 5'(i+7), 5'(i*5), 16'h0, 16'h0, 1, 16'h8001 ^ 16'(i*16'h2469), "R5 c22 read frame");
            run_frame(2'b00, 2'b11, 5'(i+3), 5'(i+20), 16'h0, 16'h0, 1, 16'h4E21 + 16'(i*977), "R5 c45 read frame");
            run_frame(2'b00, 2'b10, 5'(i+11), 5'(i+9), 16'h0, 16'h0, 1, 16'hFFFF - 16'(i*3), "R5 c45 read-inc frame");
        end

        // R9: MDC period
        chk((t_r1 - t_r0) == 2*HALF*CLK_PERIOD, "R9 mdc period", 64'(t_r1 - t_r0), 64'(2*HALF*CLK_PERIOD));

        // R8: no answer sets fail; next command clears it; answered read leaves 0
        run_frame(2'b01, 2'b10, 5'd5, 5'd1, 16'h0, 16'h0, 0, 16'h0, "R8 unanswered c22");
        run_frame(2'b00, 2'b11, 5'd6, 5'd2, 16'h0, 16'h0, 0, 16'h0, "R8 unanswered c45");
        phy_resp = 0; rcnt = 0; fcnt = 0;
        wr_reg(5'h00, cmd_word(2'b01, 2'b01, 5'd3, 5'd3));
        rd_reg(5'h10, v);
        chk(v == 32'd0, "R8 cleared on start", {32'd0, v}, 64'd0);
        wait_idle();
        run_frame(2'b01, 2'b10, 5'd9, 5'd4, 16'h0, 16'h0, 1, 16'h0000, "R8 answered read");

        // R7: command write in the middle of a frame
        wr_reg(5'h08, 32'h0000_6B6B);
        phy_resp = 0; rcnt = 0; fcnt = 0;
        wr_reg(5'h00, cmd_word(2'b01, 2'b01, 5'd17, 5'd12));
        wait (rcnt >= 10);
        wr_reg(5'h00, cmd_word(2'b00, 2'b11, 5'd2, 5'd30));
        rd_reg(5'h00, v);
        chk(v == cmd_word(2'b01, 2'b01, 5'd17, 5'd12), "R7 fields kept mid-frame", {32'd0, v},
            {32'd0, cmd_word(2'b01, 2'b01, 5'd17, 5'd12)});
        wait_idle();
        check_wire(2'b01, 2'b01, 5'd17, 5'd12, 16'h0, 16'h6B6B, "R7 frame unchanged");

        // R7: command write in the completion cycle
        rcnt = 0; fcnt = 0;
        wr_reg(5'h00, cmd_word(2'b01, 2'b01, 5'd20, 5'd21));
        wait (fcnt == 64);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = cmd_word(2'b00, 2'b00, 5'd1, 5'd1);
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (40) @(negedge clk);
        rd_reg(5'h00, v);
        chk(v == {18'd0, 2'b01, 2'b01, 5'd20, 5'd21}, "R7 completion-cycle write dropped", {32'd0, v},
            {50'd0, 2'b01, 2'b01, 5'd20, 5'd21});
        chk(rcnt == 64 && !mdc && !mdio_oe, "R7 no new frame", 64'(rcnt), 64'd64);

        finish_run();
    end
endmodule